// File: doc/BRIEF.md
# Masked Debug Watchpoint Unit

This block watches a processor's bus one access at a time and raises a halt request when the access fits conditions set up by a debugger. It holds two comparator units. Each unit compares the address, data and a small group of control signals against stored values. Every compared bit has its own mask bit. A unit is typed either as a watchpoint, which looks at data accesses, or as a breakpoint, which looks at instruction fetches.

The two units can trigger on their own. They can also be combined in a chained mode, where a hit on unit 0 arms unit 1 and a later hit on unit 1 halts. In range mode, an access halts when it lies inside the region of unit 0 but outside the region of unit 1. All configuration goes through a word-addressed register write port and a combinational read port. A control/status register selects the combining mode and reports the halt, its cause and the chain-armed flag. The halt request is registered and stays high until the core acknowledges it.

Top module: `masked_watch_unit`

## Requirements
- R1: After reset, halt_req is low and every register reads as zero.
- R2: Register words sit at these word offsets: unit u at 8*u. Within a unit, offset +0 holds the address value, +1 the address mask, +2 the data value, +3 the data mask, and +4 the control word. The control word has the control value in bits [3:0], the control mask in bits [7:4], the enable in bit 8 and the kind in bit 9. The control/status word is at offset 16, with the mode in bits [1:0]. Each field reads back as written, and unused bits and unused offsets read zero.
- R3: A unit compares only those address, data and control bits whose mask bit is 0. A mask bit of 1 excludes its bit. The unit hits only when every compared bit equals the stored value.
- R4: A unit with kind 0 hits only on data accesses (bus_fetch = 0). A unit with kind 1 hits only on instruction fetches (bus_fetch = 1).
- R5: In independent mode (mode 0 or 3), a hit on any enabled unit halts. Status bit 9 names the unit that caused the halt, and unit 0 wins when both units hit. A disabled unit never halts.
- R6: halt_req rises on the clock edge that samples the matching access and not before it. It stays high until halt_ack. While it is high, further hits leave the recorded cause unchanged. Status bit 8 mirrors halt_req.
- R7: A cycle with bus_valid low never raises a halt and never arms the chain.
- R8: In chain mode (mode 1), a hit on unit 0 sets the armed flag (status bit 11). A hit on unit 1 in a later cycle then halts with cause unit 1. A hit on unit 1 without the armed flag does not halt.
- R9: The armed flag clears when the chain halt is raised and on any register write. A register write also covers leaving chain mode.
- R10: In range mode (mode 2), an access halts when enabled unit 0 hits and unit 1's comparison misses. Unit 1's enable bit is ignored in this mode, and the cause recorded is unit 0.
- R11: Status bit 10 records the kind of the unit that caused the halt: 1 for a breakpoint, 0 for a watchpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_waddr | input | 5 | Register write word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 5 | Register read word offset |
| cfg_rdata | output | 32 | Register read data (combinational) |
| bus_valid | input | 1 | Bus access valid this cycle |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_addr | input | ADDR_W | Access address |
| bus_data | input | DATA_W | Access data |
| bus_ctrl | input | CTRL_W | Access control signals |
| halt_ack | input | 1 | Clears the halt request |
| halt_req | output | 1 | Registered halt request |

## Verification
The hardest state to reach from the ports is the armed flag in chain mode. It is set only by a real unit-0 hit and cleared by several events. The bench reaches it by running a scripted sequence of accesses: it hits unit 1 first, then unit 0, then a non-matching access, then unit 1 again. It reads the armed bit through the status word after every access. A second path arms the chain and then writes a register, which shows that the flag is cleared. The mask and range behaviour is covered by sweeping every address in a small window and comparing each halt against a value the bench computes arithmetically.

// File: rtl/wp_pkg.sv
// Package: shared constants for the masked watchpoint unit.
// Assumes: register port is 32 bits wide and word-addressed with 5 bits.
package wp_pkg;
    localparam int NUM_UNITS = 2;
    localparam int REG_W     = 32;
    localparam int REG_AW    = 5;

    // Per-unit field offsets (low three bits of the word offset)
    localparam logic [2:0] FLD_AVAL  = 3'd0;
    localparam logic [2:0] FLD_AMASK = 3'd1;
    localparam logic [2:0] FLD_DVAL  = 3'd2;
    localparam logic [2:0] FLD_DMASK = 3'd3;
    localparam logic [2:0] FLD_CTRL  = 3'd4;

    localparam logic [REG_AW-1:0] OFS_STAT = 5'd16;

    // Status bit positions in the control/status word
    localparam int ST_HALT  = 8;
    localparam int ST_UNIT  = 9;
    localparam int ST_KIND  = 10;
    localparam int ST_ARMED = 11;

    typedef enum logic [1:0] {
        MODE_INDEP = 2'd0,
        MODE_CHAIN = 2'd1,
        MODE_RANGE = 2'd2,
        MODE_ALT   = 2'd3
    } wp_mode_e;
endpackage

// File: rtl/wp_regfile.sv
// Module: wp_regfile
// Holds both units' value/mask/control words and the mode field, and serves
// the combinational read port (status bits come from the trigger logic).
// Assumes: ADDR_W, DATA_W <= 32 and 2*CTRL_W+2 <= 32.
module wp_regfile
    import wp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CTRL_W = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_wr,
    input  logic [REG_AW-1:0]              cfg_waddr,
    input  logic [REG_W-1:0]               cfg_wdata,
    input  logic [REG_AW-1:0]              cfg_raddr,
    output logic [REG_W-1:0]               cfg_rdata,
    input  logic [3:0]                     status_bits,
    output logic [NUM_UNITS-1:0][ADDR_W-1:0] addr_val,
    output logic [NUM_UNITS-1:0][ADDR_W-1:0] addr_mask,
    output logic [NUM_UNITS-1:0][DATA_W-1:0] data_val,
    output logic [NUM_UNITS-1:0][DATA_W-1:0] data_mask,
    output logic [NUM_UNITS-1:0][CTRL_W-1:0] ctrl_val,
    output logic [NUM_UNITS-1:0][CTRL_W-1:0] ctrl_mask,
    output logic [NUM_UNITS-1:0]           unit_en,
    output logic [NUM_UNITS-1:0]           unit_kind,
    output logic [1:0]                     mode
);
    localparam int CW_W = 2 * CTRL_W + 2;

    logic [NUM_UNITS-1:0][CW_W-1:0] ctrl_word;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        logic sel;
        assign sel = cfg_wr && !cfg_waddr[4] && (cfg_waddr[3] == 1'(u));

        // Store this unit's fields on a write to its word offsets
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_val[u]  <= '0;
                addr_mask[u] <= '0;
                data_val[u]  <= '0;
                data_mask[u] <= '0;
                ctrl_word[u] <= '0;
            end else if (sel) begin
                case (cfg_waddr[2:0])
                    FLD_AVAL:  addr_val[u]  <= cfg_wdata[ADDR_W-1:0];
                    FLD_AMASK: addr_mask[u] <= cfg_wdata[ADDR_W-1:0];
                    FLD_DVAL:  data_val[u]  <= cfg_wdata[DATA_W-1:0];
                    FLD_DMASK: data_mask[u] <= cfg_wdata[DATA_W-1:0];
                    FLD_CTRL:  ctrl_word[u] <= cfg_wdata[CW_W-1:0];
                    default: ;
                endcase
            end
        end

        assign ctrl_val[u]  = ctrl_word[u][CTRL_W-1:0];
        assign ctrl_mask[u] = ctrl_word[u][2*CTRL_W-1:CTRL_W];
        assign unit_en[u]   = ctrl_word[u][2*CTRL_W];
        assign unit_kind[u] = ctrl_word[u][2*CTRL_W+1];
    end

    // Store the combining mode on a write to the control/status word
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= '0;
        else if (cfg_wr && cfg_waddr == OFS_STAT)
            mode <= cfg_wdata[1:0];
    end

    // Select the read word for the requested offset
    always_comb begin
        logic ru;
        ru = cfg_raddr[3];
        cfg_rdata = '0;
        if (cfg_raddr == OFS_STAT) begin
            cfg_rdata[1:0]      = mode;
            cfg_rdata[ST_HALT]  = status_bits[0];
            cfg_rdata[ST_UNIT]  = status_bits[1];
            cfg_rdata[ST_KIND]  = status_bits[2];
            cfg_rdata[ST_ARMED] = status_bits[3];
        end else if (!cfg_raddr[4]) begin
            case (cfg_raddr[2:0])
                FLD_AVAL:  cfg_rdata = REG_W'(addr_val[ru]);
                FLD_AMASK: cfg_rdata = REG_W'(addr_mask[ru]);
                FLD_DVAL:  cfg_rdata = REG_W'(data_val[ru]);
                FLD_DMASK: cfg_rdata = REG_W'(data_mask[ru]);
                FLD_CTRL:  cfg_rdata = REG_W'(ctrl_word[ru]);
                default:   cfg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/wp_comparator.sv
// Module: wp_comparator
// One masked comparator over address, data and control signals. cmp_hit
// ignores the enable bit (range mode uses it raw); unit_hit requires enable.
// Assumes: a mask bit of 1 removes that bit from the comparison.
module wp_comparator #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CTRL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_fetch,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [CTRL_W-1:0] bus_ctrl,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic [ADDR_W-1:0] addr_mask,
    input  logic [DATA_W-1:0] data_val,
    input  logic [DATA_W-1:0] data_mask,
    input  logic [CTRL_W-1:0] ctrl_val,
    input  logic [CTRL_W-1:0] ctrl_mask,
    input  logic              en,
    input  logic              kind,
    output logic              cmp_hit,
    output logic              unit_hit
);
    logic addr_ok, data_ok, ctrl_ok;

    // Per-bit masked equality on each compared field
    always_comb begin
        addr_ok = ((bus_addr ^ addr_val) & ~addr_mask) == '0;
        data_ok = ((bus_data ^ data_val) & ~data_mask) == '0;
        ctrl_ok = ((bus_ctrl ^ ctrl_val) & ~ctrl_mask) == '0;
    end

    // Qualify with access valid and access type (fetch vs data)
    assign cmp_hit  = bus_valid && (bus_fetch == kind) && addr_ok && data_ok && ctrl_ok;
    assign unit_hit = cmp_hit && en;

    // R4
    kind_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_hit |-> (bus_fetch == kind));
endmodule

// File: rtl/wp_trigger.sv
// Module: wp_trigger
// Combines the two units' hits by mode, keeps the chain-armed flag and the
// registered halt request with its recorded cause.
// Assumes: hit inputs are already gated by bus_valid.
module wp_trigger
    import wp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_valid,
    input  logic       cfg_wr,
    input  logic [1:0] mode,
    input  logic [1:0] unit_hit,
    input  logic       cmp1,
    input  logic [1:0] unit_kind,
    input  logic       halt_ack,
    output logic       halt_req,
    output logic       cause_unit,
    output logic       cause_kind,
    output logic       armed
);
    logic trig, trig_unit, chain_on;

    assign chain_on = (mode == MODE_CHAIN);

    // Decide whether this access triggers and which unit is blamed
    always_comb begin
        trig = 1'b0;
        trig_unit = 1'b0;
        case (mode)
            MODE_CHAIN: begin
                trig = armed && unit_hit[1];
                trig_unit = 1'b1;
            end
            MODE_RANGE: begin
                trig = unit_hit[0] && !cmp1;
                trig_unit = 1'b0;
            end
            default: begin
                trig = unit_hit[0] || unit_hit[1];
                trig_unit = !unit_hit[0];
            end
        endcase
    end

    // Chain-armed flag: set by unit 0, cleared by completion or any write
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (cfg_wr || !chain_on || trig)
            armed <= 1'b0;
        else if (unit_hit[0])
            armed <= 1'b1;
    end

    // Halt request and cause: latch on first trigger, hold until acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_req   <= 1'b0;
            cause_unit <= 1'b0;
            cause_kind <= 1'b0;
        end else if (halt_ack) begin
            halt_req <= 1'b0;
        end else if (trig && !halt_req) begin
            halt_req   <= 1'b1;
            cause_unit <= trig_unit;
            cause_kind <= unit_kind[trig_unit];
        end
    end

    // R6
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req && !halt_ack |=> halt_req);
    // R6
    cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req && !halt_ack |=> $stable(cause_unit) && $stable(cause_kind));
    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid && !halt_req |=> !halt_req);
    // R9
    write_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !armed);
    // R8
    chain_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_req) && $past(mode) == MODE_CHAIN |-> $past(armed) && cause_unit);
    // R10
    range_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_req) && $past(mode) == MODE_RANGE |-> !$past(cmp1) && !cause_unit);
endmodule

// File: rtl/masked_watch_unit.sv
// Module: masked_watch_unit (top)
// Two masked bus comparators with independent, chained or range triggering
// and a registered halt request; configured through a word register port.
// Assumes: bus signals are sampled once per cycle when bus_valid is high.
module masked_watch_unit
    import wp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CTRL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [4:0]        cfg_waddr,
    input  logic [31:0]       cfg_wdata,
    input  logic [4:0]        cfg_raddr,
    output logic [31:0]       cfg_rdata,
    input  logic              bus_valid,
    input  logic              bus_fetch,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [CTRL_W-1:0] bus_ctrl,
    input  logic              halt_ack,
    output logic              halt_req
);
    logic [NUM_UNITS-1:0][ADDR_W-1:0] addr_val, addr_mask;
    logic [NUM_UNITS-1:0][DATA_W-1:0] data_val, data_mask;
    logic [NUM_UNITS-1:0][CTRL_W-1:0] ctrl_val, ctrl_mask;
    logic [NUM_UNITS-1:0] unit_en, unit_kind, cmp_hit, unit_hit;
    logic [1:0] mode;
    logic cause_unit, cause_kind, armed;

    wp_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_waddr(cfg_waddr),
        .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .status_bits({armed, cause_kind, cause_unit, halt_req}),
        .addr_val(addr_val), .addr_mask(addr_mask),
        .data_val(data_val), .data_mask(data_mask),
        .ctrl_val(ctrl_val), .ctrl_mask(ctrl_mask),
        .unit_en(unit_en), .unit_kind(unit_kind), .mode(mode)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_cmp
        wp_comparator #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_cmp (
            .clk(clk), .rst_n(rst_n),
            .bus_valid(bus_valid), .bus_fetch(bus_fetch),
            .bus_addr(bus_addr), .bus_data(bus_data), .bus_ctrl(bus_ctrl),
            .addr_val(addr_val[u]), .addr_mask(addr_mask[u]),
            .data_val(data_val[u]), .data_mask(data_mask[u]),
            .ctrl_val(ctrl_val[u]), .ctrl_mask(ctrl_mask[u]),
            .en(unit_en[u]), .kind(unit_kind[u]),
            .cmp_hit(cmp_hit[u]), .unit_hit(unit_hit[u])
        );
    end

    wp_trigger u_trig (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .cfg_wr(cfg_wr),
        .mode(mode), .unit_hit(unit_hit), .cmp1(cmp_hit[1]),
        .unit_kind(unit_kind), .halt_ack(halt_ack),
        .halt_req(halt_req), .cause_unit(cause_unit),
        .cause_kind(cause_kind), .armed(armed)
    );

    // R7
    no_idle_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> cmp_hit == '0);
endmodule

// File: tb/masked_watch_unit_tb.sv
`timescale 1ns/100ps
module masked_watch_unit_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [4:0] cfg_waddr = '0, cfg_raddr = 5'd16;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic bus_valid = 1'b0, bus_fetch = 1'b0;
    logic [31:0] bus_addr = '0, bus_data = '0;
    logic [3:0] bus_ctrl = '0;
    logic halt_ack = 1'b0, halt_req;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    masked_watch_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_waddr(cfg_waddr),
        .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .bus_valid(bus_valid), .bus_fetch(bus_fetch), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_ctrl(bus_ctrl), .halt_ack(halt_ack),
        .halt_req(halt_req)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_waddr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_raddr = a;
        #1 d = cfg_rdata;
        cfg_raddr = 5'd16;
    endtask

    task automatic set_unit(input int u, input logic [31:0] av, am, dv, dm,
                            input logic [3:0] cv, cm, input logic en, kind);
        logic [4:0] b;
        b = 5'(u * 8);
        wr(b + 5'd0, av); wr(b + 5'd1, am); wr(b + 5'd2, dv); wr(b + 5'd3, dm);
        wr(b + 5'd4, {22'd0, kind, en, cm, cv});
    endtask

    // One access cycle; returns halt before and after the sampling edge and the status word
    task automatic access(input logic f, input logic [31:0] a, d, input logic [3:0] c,
                          input bit ack, output logic pre, output logic h, output logic [31:0] st);
        @(negedge clk);
        bus_valid = 1'b1; bus_fetch = f; bus_addr = a; bus_data = d; bus_ctrl = c;
        #1 pre = halt_req;
        @(negedge clk);
        bus_valid = 1'b0;
        #1 h = halt_req; st = cfg_rdata;
        if (ack) begin
            halt_ack = 1'b1;
            @(negedge clk);
            halt_ack = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r, st;
        logic pre, h;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1 chk(halt_req == 1'b0, "R1 halt", {31'd0, halt_req}, 0);
        for (int a = 0; a < 17; a++) begin
            rd(5'(a), r);
            chk(r == 0, "R1 reg", r, 0);
        end

        // R2: readback of every field, masking of unused bits
        for (int u = 0; u < 2; u++) begin
            for (int f = 0; f < 5; f++) begin
                logic [31:0] v;
                v = 32'hA5C3_0F00 ^ (32'(u) << 28) ^ (32'(f) * 32'h0101_1111);
                wr(5'(u * 8 + f), v);
                rd(5'(u * 8 + f), r);
                chk(r == ((f == 4) ? (v & 32'h3FF) : v), "R2 field", r, (f == 4) ? (v & 32'h3FF) : v);
            end
            wr(5'(u * 8 + 5), 32'hFFFF_FFFF);
            rd(5'(u * 8 + 5), r);
            chk(r == 0, "R2 unused", r, 0);
        end
        wr(5'd16, 32'hFFFF_FFFE);
        rd(5'd16, r);
        chk(r == 32'h2, "R2 mode", r, 32'h2);

        // R3: address mask sweep, unit 0 value 0x5A
        wr(5'd16, 0);
        set_unit(1, 0, 0, 0, 0, 0, 0, 1'b0, 1'b0);
        for (int mi = 0; mi < 4; mi++) begin
            logic [7:0] m;
            m = (mi == 0) ? 8'h00 : (mi == 1) ? 8'h0F : (mi == 2) ? 8'hF0 : 8'h81;
            set_unit(0, 32'h5A, {24'hFFFFFF, m}, 0, 32'hFFFF_FFFF, 0, 4'hF, 1'b1, 1'b0);
            for (int a = 0; a < 256; a++) begin
                logic e;
                e = ((8'(a) ^ 8'h5A) & ~m) == 8'h00;
                access(1'b0, 32'(a), 0, 0, 1'b1, pre, h, st);
                chk(h == e, "R3 addr mask", {31'd0, h}, {31'd0, e});
            end
        end
        // R3: data mask, low 4 bits compared against 0xC
        set_unit(0, 0, 32'hFFFF_FFFF, 32'h3C, 32'hFFFF_FFF0, 0, 4'hF, 1'b1, 1'b0);
        for (int d = 0; d < 64; d++) begin
            logic e;
            e = (d % 16) == 12;
            access(1'b0, 0, 32'(d), 0, 1'b1, pre, h, st);
            chk(h == e, "R3 data mask", {31'd0, h}, {31'd0, e});
        end
        // R3: control mask, unmasked then upper two bits only
        for (int cm = 0; cm < 2; cm++) begin
            set_unit(0, 0, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, 4'hA, (cm == 0) ? 4'h0 : 4'h3, 1'b1, 1'b0);
            for (int c = 0; c < 16; c++) begin
                logic e;
                e = (cm == 0) ? (c == 10) : ((c / 4) == 2);
                access(1'b0, 0, 0, 4'(c), 1'b1, pre, h, st);
                chk(h == e, "R3 ctrl mask", {31'd0, h}, {31'd0, e});
            end
        end

        // R4 / R11: access type and recorded kind
        for (int k = 0; k < 2; k++) begin
            set_unit(0, 0, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, 0, 4'hF, 1'b1, 1'(k));
            for (int f = 0; f < 2; f++) begin
                access(1'(f), 32'h1234, 0, 0, 1'b1, pre, h, st);
                chk(h == (f == k), "R4 kind", {31'd0, h}, {31'(f == k)});
                if (f == k) chk(st[10] == 1'(k), "R11 cause kind", {31'd0, st[10]}, 32'(k));
            end
        end

        // R5: enables and cause unit in independent mode (mode 3 as well)
        set_unit(0, 0, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, 0, 4'hF, 1'b0, 1'b0);
        set_unit(1, 0, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, 0, 4'hF, 1'b0, 1'b0);
        access(1'b0, 0, 0, 0, 1'b1, pre, h, st);
        chk(h == 0, "R5 both disabled", {31'd0, h}, 0);
        wr(5'd12, 32'h100);
        access(1'b0, 0, 0, 0, 1'b1, pre, h, st);
        chk(h == 1 && st[9] == 1, "R5 unit1 cause", st, 32'h300);
        wr(5'd4, 32'h100);
        wr(5'd16, 32'd3);
        access(1'b0, 0, 0, 0, 1'b1, pre, h, st);
        chk(h == 1 && st[9] == 0, "R5 unit0 priority", st, 32'h103);

        // R6: registered, held, cause frozen, released by ack
        wr(5'd16, 0);
        set_unit(0, 32'h40, 0, 0, 32'hFFFF_FFFF, 0, 4'hF, 1'b1, 1'b0);
        set_unit(1, 32'h80, 0, 0, 32'hFFFF_FFFF, 0, 4'hF, 1'b1, 1'b1);
        access(1'b0, 32'h40, 0, 0, 1'b0, pre, h, st);
        chk(pre == 0 && h == 1, "R6 one edge", {30'd0, pre, h}, 32'h1);
        chk(st[8] == 1, "R6 status mirror", st, 32'h100);
        access(1'b1, 32'h80, 0, 0, 1'b0, pre, h, st);
        chk(h == 1 && st[9] == 0 && st[10] == 0, "R6 cause frozen", st, 32'h100);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(halt_req == 1, "R6 held", {31'd0, halt_req}, 1);
        end
        @(negedge clk); halt_ack = 1'b1;
        @(negedge clk); halt_ack = 1'b0;
        #1 chk(halt_req == 0, "R6 ack", {31'd0, halt_req}, 0);

        // R7: idle cycles with matching values do nothing
        @(negedge clk);
        bus_valid = 1'b0; bus_fetch = 1'b0; bus_addr = 32'h40;
        repeat (5) @(negedge clk);
        chk(halt_req == 0, "R7 idle no halt", {31'd0, halt_req}, 0);

        // R8 / R9: chain sequence
        set_unit(0, 32'h100, 0, 0, 32'hFFFF_FFFF, 0, 4'hF, 1'b1, 1'b0);
        set_unit(1, 32'h200, 0, 0, 32'hFFFF_FFFF, 0, 4'hF, 1'b1, 1'b0);
        wr(5'd16, 32'd1);
        @(negedge clk); bus_valid = 1'b0; bus_addr = 32'h100;
        repeat (3) @(negedge clk);
        rd(5'd16, r);
        chk(r[11] == 0, "R7 idle no arm", r, 32'h1);
        access(1'b0, 32'h200, 0, 0, 1'b1, pre, h, st);
        chk(h == 0, "R8 unarmed unit1", {31'd0, h}, 0);
        access(1'b0, 32'h100, 0, 0, 1'b1, pre, h, st);
        chk(h == 0 && st[11] == 1, "R8 arm", st, 32'h801);
        access(1'b0, 32'h300, 0, 0, 1'b1, pre, h, st);
        chk(h == 0 && st[11] == 1, "R8 stays armed", st, 32'h801);
        access(1'b0, 32'h200, 0, 0, 1'b0, pre, h, st);
        chk(h == 1 && st[9] == 1 && st[11] == 0, "R8 chain halt / R9 clear", st, 32'h301);
        @(negedge clk); halt_ack = 1'b1;
        @(negedge clk); halt_ack = 1'b0;
        access(1'b0, 32'h100, 0, 0, 1'b1, pre, h, st);
        chk(st[11] == 1, "R9 re-arm", st, 32'h801);
        wr(5'd2, 0);
        rd(5'd16, r);
        chk(r[11] == 0, "R9 write clears", r, 32'h1);
        access(1'b0, 32'h200, 0, 0, 1'b1, pre, h, st);
        chk(h == 0, "R9 no halt after clear", {31'd0, h}, 0);

        // R10: range sweep, inside 256-byte region but outside lowest 32 bytes
        set_unit(0, 0, 32'hFF, 0, 32'hFFFF_FFFF, 0, 4'hF, 1'b1, 1'b0);
        set_unit(1, 0, 32'h1F, 0, 32'hFFFF_FFFF, 0, 4'hF, 1'b0, 1'b0);
        wr(5'd16, 32'd2);
        for (int a = 0; a < 320; a++) begin
            logic e;
            e = (a >= 32) && (a < 256);
            access(1'b0, 32'(a), 0, 0, 1'b1, pre, h, st);
            chk(h == e, "R10 range", 32'(a), {31'd0, e});
            if (e) chk(st[9] == 0, "R10 cause", st, 32'h102);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule